// File: doc/BRIEF.md
# Platform System Control Register Bank

This block is the byte-wide register bank of a board-level system controller, reached over a plain I/O bus made of an address, a write strobe, a read strobe, write data and registered read data. It answers one legacy control port at 0x0092 and a cluster of ports between 0x0800 and 0x0851. Some of these ports hold control state: a little-endian mode flag, a disk activity lamp, a 4-bit system control field and an I/O map type bit. Others return fixed identity and equipment bytes. A few only fire one-cycle side-effect pulses at neighbouring logic. These neighbours are a soft CPU reset, cache invalidation and two NVRAM lock toggles.

Each port has separate meanings for reads and writes. A port can return a constant when read and fire a strobe when written, and a port that has no read meaning returns all ones. A write to a port that has no write meaning raises an error pulse. The one exception is the three identity ports, which take writes silently. Addresses are compared at the full bus width, so no port answers at an alias.

Top module: `sysctl_regbank`

## Requirements
- R1: A write to 0x0092 loads the little-endian flag `le_mode` from data bit 1. A read of 0x0092 returns 0x00.
- R2: A write to 0x0092 with data bit 0 set raises `soft_rst_pulse` for exactly one cycle. With bit 0 clear there is no pulse.
- R3: A write to 0x0808 loads `disk_led` from data bit 0. A read of 0x0808 returns 0xFF.
- R4: A write to 0x0810 pulses `lock1_pulse` for one cycle, and a write to 0x0812 pulses `lock2_pulse` for one cycle. A read of 0x0810 returns 0x39 and a read of 0x0812 returns 0xFF.
- R5: A write to 0x081C stores data bits 3:0 in `sys_ctl`. A read of 0x081C returns the stored field with zeros above it.
- R6: A write to 0x0850 stores data bit 0 in `map_sparse`. A read of 0x0850 returns that bit with zeros above it.
- R7: Reads of the fixed ports return these values: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0818 gives 0x00 and 0x0823 gives 0x03.
- R8: Writes to 0x0800, 0x0802 and 0x0803 change no stored bit, fire no pulse and raise no error.
- R9: A write to 0x0814 pulses `cinv_pulse` for one cycle. A read of 0x0814 returns 0xFF.
- R10: A read of any address not named in R1 to R9 returns 0xFF, including aliases that differ only in the upper address bits.
- R11: A write to any address other than 0x0092, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C and 0x0850 raises `bad_wr_pulse` for one cycle and changes no stored bit.
- R12: After reset, all stored bits, all pulses and `io_rdata` are zero.
- R13: Stored bits and pulses change on the clock edge that samples `io_wr`. `io_rdata` is loaded on the edge that samples `io_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | Port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Registered read data |
| le_mode | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk activity lamp |
| sys_ctl | output | CTL_W | System control field |
| map_sparse | output | 1 | I/O map type bit |
| soft_rst_pulse | output | 1 | Soft reset request pulse |
| lock1_pulse | output | 1 | NVRAM lock toggle 1 pulse |
| lock2_pulse | output | 1 | NVRAM lock toggle 2 pulse |
| cinv_pulse | output | 1 | Cache invalidate pulse |
| bad_wr_pulse | output | 1 | Pulse on a write to a port with no write meaning |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data, a 4-bit control field, and read data that holds between reads. The full 16-bit address lets the bench try aliases such as 0x1810 and 0x8092, as well as the edges of the window at 0x07FF and 0x0851, so it can show that decoding uses every address bit. Random reads and writes over the decoded ports and their neighbours are checked against a bench model. Some read ports also fire strobes when written, and the bench checks that the read value and the write side effect stay separate.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   typedef enum logic [3:0] {
      PORT_NONE,
      PORT_SPECIAL,
      PORT_CPUCFG,
      PORT_FEAT,
      PORT_STAT,
      PORT_LED,
      PORT_EQUIP,
      PORT_LOCK1,
      PORT_LOCK2,
      PORT_CINV,
      PORT_KEYLK,
      PORT_CTL,
      PORT_L2ST,
      PORT_MAP
   } port_e;

   localparam int unsigned A_SPECIAL = 32'h0092;
   localparam int unsigned A_CPUCFG  = 32'h0800;
   localparam int unsigned A_FEAT    = 32'h0802;
   localparam int unsigned A_STAT    = 32'h0803;
   localparam int unsigned A_LED     = 32'h0808;
   localparam int unsigned A_EQUIP   = 32'h080C;
   localparam int unsigned A_LOCK1   = 32'h0810;
   localparam int unsigned A_LOCK2   = 32'h0812;
   localparam int unsigned A_CINV    = 32'h0814;
   localparam int unsigned A_KEYLK   = 32'h0818;
   localparam int unsigned A_CTL     = 32'h081C;
   localparam int unsigned A_L2ST    = 32'h0823;
   localparam int unsigned A_MAP     = 32'h0850;

   localparam logic [7:0] K_CPUCFG = 8'hEF;
   localparam logic [7:0] K_FEAT   = 8'hAD;
   localparam logic [7:0] K_STAT   = 8'hE0;
   localparam logic [7:0] K_EQUIP  = 8'h3C;
   localparam logic [7:0] K_EXTF   = 8'h39;
   localparam logic [7:0] K_KEYLK  = 8'h00;
   localparam logic [7:0] K_L2ST   = 8'h03;
   localparam logic [7:0] K_SPEC   = 8'h00;

   function automatic logic port_writable(port_e p);
      case (p)
         PORT_SPECIAL, PORT_CPUCFG, PORT_FEAT, PORT_STAT, PORT_LED,
         PORT_LOCK1, PORT_LOCK2, PORT_CINV, PORT_CTL, PORT_MAP: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output port_e             port
);

   always_comb begin
      case (addr)
         ADDR_W'(A_SPECIAL): port = PORT_SPECIAL;
         ADDR_W'(A_CPUCFG):  port = PORT_CPUCFG;
         ADDR_W'(A_FEAT):    port = PORT_FEAT;
         ADDR_W'(A_STAT):    port = PORT_STAT;
         ADDR_W'(A_LED):     port = PORT_LED;
         ADDR_W'(A_EQUIP):   port = PORT_EQUIP;
         ADDR_W'(A_LOCK1):   port = PORT_LOCK1;
         ADDR_W'(A_LOCK2):   port = PORT_LOCK2;
         ADDR_W'(A_CINV):    port = PORT_CINV;
         ADDR_W'(A_KEYLK):   port = PORT_KEYLK;
         ADDR_W'(A_CTL):     port = PORT_CTL;
         ADDR_W'(A_L2ST):    port = PORT_L2ST;
         ADDR_W'(A_MAP):     port = PORT_MAP;
         default:            port = PORT_NONE;
      endcase
   end

endmodule

// File: rtl/sysctl_state.sv
module sysctl_state
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CTL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  port_e             port,
   input  logic [DATA_W-1:0] wdata,
   output logic              le_mode,
   output logic              disk_led,
   output logic [CTL_W-1:0]  sys_ctl,
   output logic              map_sparse,
   output logic              soft_rst_pulse,
   output logic              lock1_pulse,
   output logic              lock2_pulse,
   output logic              cinv_pulse,
   output logic              bad_wr_pulse
);

   logic wr_ok;
   assign wr_ok = port_writable(port);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         le_mode    <= 1'b0;
         disk_led   <= 1'b0;
         sys_ctl    <= '0;
         map_sparse <= 1'b0;
      end else if (wr_en) begin
         case (port)
            PORT_SPECIAL: le_mode    <= wdata[1];
            PORT_LED:     disk_led   <= wdata[0];
            PORT_CTL:     sys_ctl    <= wdata[CTL_W-1:0];
            PORT_MAP:     map_sparse <= wdata[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_rst_pulse <= 1'b0;
         lock1_pulse    <= 1'b0;
         lock2_pulse    <= 1'b0;
         cinv_pulse     <= 1'b0;
         bad_wr_pulse   <= 1'b0;
      end else begin
         soft_rst_pulse <= wr_en && (port == PORT_SPECIAL) && wdata[0];
         lock1_pulse    <= wr_en && (port == PORT_LOCK1);
         lock2_pulse    <= wr_en && (port == PORT_LOCK2);
         cinv_pulse     <= wr_en && (port == PORT_CINV);
         bad_wr_pulse   <= wr_en && !wr_ok;
      end
   end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CTL_W      = 4,
   parameter bit HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  port_e             port,
   input  logic [CTL_W-1:0]  sys_ctl,
   input  logic              map_sparse,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      case (port)
         PORT_SPECIAL: rd_next = DATA_W'(K_SPEC);
         PORT_CPUCFG:  rd_next = DATA_W'(K_CPUCFG);
         PORT_FEAT:    rd_next = DATA_W'(K_FEAT);
         PORT_STAT:    rd_next = DATA_W'(K_STAT);
         PORT_EQUIP:   rd_next = DATA_W'(K_EQUIP);
         PORT_LOCK1:   rd_next = DATA_W'(K_EXTF);
         PORT_KEYLK:   rd_next = DATA_W'(K_KEYLK);
         PORT_L2ST:    rd_next = DATA_W'(K_L2ST);
         PORT_CTL:     rd_next = DATA_W'(sys_ctl);
         PORT_MAP:     rd_next = DATA_W'(map_sparse);
         default:      rd_next = '1;
      endcase
   end

   generate
      if (HOLD_RDATA) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_en) rdata <= rd_next;
         end
      end else begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_en ? rd_next : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
   import sysctl_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int CTL_W      = 4,
   parameter bit HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              le_mode,
   output logic              disk_led,
   output logic [CTL_W-1:0]  sys_ctl,
   output logic              map_sparse,
   output logic              soft_rst_pulse,
   output logic              lock1_pulse,
   output logic              lock2_pulse,
   output logic              cinv_pulse,
   output logic              bad_wr_pulse
);

   localparam int MIN_ADDR_W = $clog2(A_MAP + 1);

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the port window");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (CTL_W < 1 || CTL_W > DATA_W) begin : g_bad_ctl
         $error("CTL_W must lie in 1..DATA_W");
      end
   endgenerate

   port_e port;

   sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (io_addr),
      .port (port)
   );

   sysctl_state #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_state (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (io_wr),
      .port           (port),
      .wdata          (io_wdata),
      .le_mode        (le_mode),
      .disk_led       (disk_led),
      .sys_ctl        (sys_ctl),
      .map_sparse     (map_sparse),
      .soft_rst_pulse (soft_rst_pulse),
      .lock1_pulse    (lock1_pulse),
      .lock2_pulse    (lock2_pulse),
      .cinv_pulse     (cinv_pulse),
      .bad_wr_pulse   (bad_wr_pulse)
   );

   sysctl_rdmux #(.DATA_W(DATA_W), .CTL_W(CTL_W), .HOLD_RDATA(HOLD_RDATA)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (io_rd),
      .port       (port),
      .sys_ctl    (sys_ctl),
      .map_sparse (map_sparse),
      .rdata      (io_rdata)
   );

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CTL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic              le_mode,
   input logic              disk_led,
   input logic [CTL_W-1:0]  sys_ctl,
   input logic              map_sparse,
   input logic              soft_rst_pulse,
   input logic              lock1_pulse,
   input logic              lock2_pulse,
   input logic              cinv_pulse,
   input logic              bad_wr_pulse
);

   assert_le_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == ADDR_W'(16'h0092)) |=> (le_mode == $past(io_wdata[1])));

   assert_led_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == ADDR_W'(16'h0808)) |=> (disk_led == $past(io_wdata[0])));

   assert_lock1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == ADDR_W'(16'h0810)) |=> lock1_pulse);

   assert_ctl_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == ADDR_W'(16'h081C)) |=> (sys_ctl == $past(io_wdata[CTL_W-1:0])));

   assert_cpucfg_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == ADDR_W'(16'h0800)) |=> (io_rdata == DATA_W'(8'hEF)));

   assert_pulse_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({soft_rst_pulse, lock1_pulse, lock2_pulse, cinv_pulse, bad_wr_pulse}));

   assert_hold_state_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> ($stable(le_mode) && $stable(disk_led) && $stable(sys_ctl) && $stable(map_sparse)));

   assert_no_pulse_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> !(soft_rst_pulse || lock1_pulse || lock2_pulse || cinv_pulse || bad_wr_pulse));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .io_addr        (io_addr),
   .io_wr          (io_wr),
   .io_rd          (io_rd),
   .io_wdata       (io_wdata),
   .io_rdata       (io_rdata),
   .le_mode        (le_mode),
   .disk_led       (disk_led),
   .sys_ctl        (sys_ctl),
   .map_sparse     (map_sparse),
   .soft_rst_pulse (soft_rst_pulse),
   .lock1_pulse    (lock1_pulse),
   .lock2_pulse    (lock2_pulse),
   .cinv_pulse     (cinv_pulse),
   .bad_wr_pulse   (bad_wr_pulse)
);

// File: tb/tb_sysctl_regbank.sv
`timescale 1ns/1ps
module tb_sysctl_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        le_mode, disk_led, map_sparse;
   logic [3:0]  sys_ctl;
   logic        soft_rst_pulse, lock1_pulse, lock2_pulse, cinv_pulse, bad_wr_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic       m_le, m_led, m_map;
   logic [3:0] m_ctl;
   logic [7:0] m_rd;

   always #2.5 clk = ~clk;

   sysctl_regbank dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .le_mode(le_mode), .disk_led(disk_led),
      .sys_ctl(sys_ctl), .map_sparse(map_sparse), .soft_rst_pulse(soft_rst_pulse),
      .lock1_pulse(lock1_pulse), .lock2_pulse(lock2_pulse), .cinv_pulse(cinv_pulse),
      .bad_wr_pulse(bad_wr_pulse)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(logic [15:0] a);
      case (a)
         16'h0092: return 8'h00;
         16'h0800: return 8'hEF;
         16'h0802: return 8'hAD;
         16'h0803: return 8'hE0;
         16'h080C: return 8'h3C;
         16'h0810: return 8'h39;
         16'h0818: return 8'h00;
         16'h0823: return 8'h03;
         16'h081C: return {4'h0, m_ctl};
         16'h0850: return {7'h0, m_map};
         default:  return 8'hFF;
      endcase
   endfunction

   function automatic logic wr_known(logic [15:0] a);
      case (a)
         16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h0810,
         16'h0812, 16'h0814, 16'h081C, 16'h0850: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [15:0] pick_addr(int i);
      case (i)
         0: return 16'h0092;  1: return 16'h0800;  2: return 16'h0802;
         3: return 16'h0803;  4: return 16'h0808;  5: return 16'h080C;
         6: return 16'h0810;  7: return 16'h0812;  8: return 16'h0814;
         9: return 16'h0818;  10: return 16'h081C; 11: return 16'h0823;
         12: return 16'h0850; 13: return 16'h0851; 14: return 16'h07FF;
         15: return 16'h1810; 16: return 16'h8092; 17: return 16'h0801;
         default: return 16'h0800 + 16'($urandom_range(0, 16'h60));
      endcase
   endfunction

   task automatic check_state(string req);
      chk({req, " le_mode"},  le_mode,  m_le);
      chk({req, " disk_led"}, disk_led, m_led);
      chk({req, " sys_ctl"},  sys_ctl,  m_ctl);
      chk({req, " map"},      map_sparse, m_map);
   endtask

   task automatic do_write(logic [15:0] a, logic [7:0] d);
      logic [4:0] exp_p;
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      case (a)
         16'h0092: m_le  = d[1];
         16'h0808: m_led = d[0];
         16'h081C: m_ctl = d[3:0];
         16'h0850: m_map = d[0];
         default: ;
      endcase
      exp_p = {a == 16'h0092 && d[0], a == 16'h0810, a == 16'h0812,
               a == 16'h0814, !wr_known(a)};
      // R2 R4 R9 R11 R8: pulse pattern in the cycle after the write edge
      chk($sformatf("R2/R4/R9/R11 pulses wr %h", a),
          {soft_rst_pulse, lock1_pulse, lock2_pulse, cinv_pulse, bad_wr_pulse}, exp_p);
      check_state($sformatf("R1/R3/R5/R6/R8 wr %h", a));
      @(negedge clk);
      // R13: pulses last one cycle only
      chk("R13 pulse width", {soft_rst_pulse, lock1_pulse, lock2_pulse, cinv_pulse, bad_wr_pulse}, 5'b0);
   endtask

   task automatic do_read(logic [15:0] a, string req);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      m_rd = exp_read(a);
      chk($sformatf("%s rd %h", req, a), io_rdata, m_rd);
      io_addr = 16'h0800;
      @(negedge clk);
      chk("R13 rdata hold", io_rdata, m_rd);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_le = 0; m_led = 0; m_map = 0; m_ctl = 0; m_rd = 0;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 rdata", io_rdata, 8'h00);
      check_state("R12");
      chk("R12 pulses", {soft_rst_pulse, lock1_pulse, lock2_pulse, cinv_pulse, bad_wr_pulse}, 5'b0);
      rst_n = 1'b1;

      // Directed corner cases
      do_write(16'h0092, 8'h02);            // R1 set, R2 no pulse
      do_write(16'h0092, 8'h01);            // R1 clear, R2 pulse
      do_read (16'h0092, "R1");
      do_write(16'h0808, 8'hFF);            // R3
      do_read (16'h0808, "R3");
      do_write(16'h0810, 8'h00);            // R4
      do_write(16'h0812, 8'h00);            // R4
      do_read (16'h0810, "R4");
      do_read (16'h0812, "R4");
      do_write(16'h081C, 8'hA7);            // R5 high bits dropped
      do_read (16'h081C, "R5");
      do_write(16'h0850, 8'hFE);            // R6 bit0 only
      do_read (16'h0850, "R6");
      do_write(16'h0850, 8'h01);
      do_read (16'h0850, "R6");
      do_read (16'h0800, "R7"); do_read(16'h0802, "R7"); do_read(16'h0803, "R7");
      do_read (16'h080C, "R7"); do_read(16'h0818, "R7"); do_read(16'h0823, "R7");
      do_write(16'h0800, 8'hFF);            // R8 ignored
      do_write(16'h0802, 8'h00);
      do_write(16'h0803, 8'h55);
      do_read (16'h0800, "R8");
      do_write(16'h0814, 8'h00);            // R9
      do_read (16'h0814, "R9");
      do_read (16'h0851, "R10"); do_read(16'h07FF, "R10"); do_read(16'h1810, "R10");
      do_write(16'h080C, 8'hFF);            // R11 read-only port write
      do_write(16'h8092, 8'h03);            // R11 alias must not touch le_mode
      do_write(16'h0851, 8'h01);

      // Constrained random
      for (int n = 0; n < 400; n++) begin
         logic [15:0] a;
         a = pick_addr(int'($urandom_range(0, 22)));
         if ($urandom_range(0, 1) == 0) do_write(a, 8'($urandom));
         else                           do_read(a, "R10/R7 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule